// File: doc/BRIEF.md
# One-Time-Programmable Memory Mode Controller

This block is a synthesizable, cycle-based model of the control side of a byte-wide one-time-programmable memory. Analog conditions are represented as logic flags. One flag stands for the programming supply being present on the output-enable line. The other stands for the raised level on the address line used for identification. The block decodes the active-low chip and output enables and these two flags into six modes: standby, program-inhibit, program, output-disable, read (which also serves as program verify) and identification.

The storage is a parameterised array of `2**ADDR_W` bytes. Reset represents the delivered state, so every cell is erased to all ones. In program mode, each clock stores the bitwise AND of the cell and the input byte. Bits can therefore only move from one to zero, and holding chip enable low for several clocks repeats the write harmlessly.

The data bus appears as a data-out and drive-enable pair plus a separate input byte. With `OUT_REG=1` (the default) both outputs are registered, so they show the result for the inputs sampled at the previous rising clock edge. With `OUT_REG=0` the outputs are combinational.

In identification mode the array is bypassed. Address bit 1 high selects the maker byte (address bit 0 low) or the device byte (address bit 0 high). Address bit 1 low selects the continuation byte.

Top module: `otp_mem_ctrl`

## Requirements
- R1: While `rst_n` is low, `dq_oe` and `dq_out` are both 0.
- R2: With `ce_n` high and `vpp_hi` low (standby), `dq_oe` is 0 whatever `oe_n` is.
- R3: With `ce_n` low, `oe_n` high and `vpp_hi` low (output disable), `dq_oe` is 0, also when `id_hi` is high.
- R4: With `ce_n` low, `oe_n` low, `vpp_hi` low and `id_hi` low, `dq_oe` is 1 and `dq_out` is the byte stored at `addr`, one clock after the inputs are sampled (default latency).
- R5: After reset every cell reads 0xFF.
- R6: With `vpp_hi` high and `ce_n` low (program), `dq_oe` is 0 and the cell at `addr` becomes its old value AND `dq_in` on each clock. Other cells are unchanged.
- R7: Programming a 1 into a bit that already holds 0 leaves that bit at 0.
- R8: With `vpp_hi` high and `ce_n` high (inhibit), `dq_oe` is 0 and no cell changes.
- R9: In a read with `id_hi` high and `addr[1]` high, `dq_out` is 0x1C when `addr[0]` is 0 and 0x83 when `addr[0]` is 1, with `dq_oe` at 1.
- R10: In a read with `id_hi` high and `addr[1]` low, `dq_out` is 0x7F for either value of `addr[0]`.
- R11: Every identification byte has an odd number of ones, with bit 7 acting as the parity bit. This is checked on the maker and device codes at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; erases the array |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming supply present on the output-enable line |
| id_hi | input | 1 | Raised level on the identification address line |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Data byte to program |
| dq_out | output | DATA_W | Data byte driven to the bus |
| dq_oe | output | 1 | Bus drive enable for `dq_out` |

## Verification
The bench programs a cell, then tries to restore its cleared bits and writes all ones on top. A design that wrote instead of ANDing would read back the new value rather than the surviving zeros.

An inhibited program with an all-zero byte, followed by a read, exposes a design that lets the programming supply alone trigger a write. The top address is programmed next to an untouched neighbour, which catches address decoding that spills into adjacent cells.

All four identification address combinations are read back and their parity is checked. Swapped codes, or a continuation byte keyed on the wrong address bit, therefore show up directly. Output-disable is also applied with the identification flag raised, which catches a decoder that lets identification override output enable.

// File: rtl/otp_mem_pkg.sv
package otp_mem_pkg;

   typedef enum logic [2:0] {
      MODE_STANDBY = 3'd0,
      MODE_INHIBIT = 3'd1,
      MODE_PROGRAM = 3'd2,
      MODE_DISABLE = 3'd3,
      MODE_READ    = 3'd4,
      MODE_IDENT   = 3'd5
   } otp_mode_e;

   function automatic logic mode_drives(input otp_mode_e m);
      return (m == MODE_READ) || (m == MODE_IDENT);
   endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
   import otp_mem_pkg::*;
(
   input  logic      ce_n,
   input  logic      oe_n,
   input  logic      vpp_hi,
   input  logic      id_hi,
   output otp_mode_e mode
);

   // The programming supply shares the output-enable line, so it is
   // tested before oe_n; chip enable decides everything first.
   always_comb begin
      if (ce_n)
         mode = vpp_hi ? MODE_INHIBIT : MODE_STANDBY;
      else if (vpp_hi)
         mode = MODE_PROGRAM;
      else if (oe_n)
         mode = MODE_DISABLE;
      else if (id_hi)
         mode = MODE_IDENT;
      else
         mode = MODE_READ;
   end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   // Reset models the delivered (erased) state; writes may only clear bits.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            cells[i] <= '1;
      end else if (wr_en) begin
         cells[addr] <= cells[addr] & wr_data;
      end
   end

   assign rd_data = cells[addr];

endmodule

// File: rtl/otp_id_source.sv
module otp_id_source #(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] MFR_CODE  = 'h1C,
   parameter logic [DATA_W-1:0] DEV_CODE  = 'h83,
   parameter logic [DATA_W-1:0] CONT_CODE = 'h7F
) (
   input  logic              sel_dev,
   input  logic              id_page,
   output logic [DATA_W-1:0] code
);

   // Elaboration-time guard: identification bytes must carry odd parity.
   if (^MFR_CODE != 1'b1) begin : g_bad_mfr_parity
      $error("otp_id_source: maker code must have odd parity");
   end
   if (^DEV_CODE != 1'b1) begin : g_bad_dev_parity
      $error("otp_id_source: device code must have odd parity");
   end

   always_comb begin
      if (!id_page)
         code = CONT_CODE;
      else if (sel_dev)
         code = DEV_CODE;
      else
         code = MFR_CODE;
   end

endmodule

// File: rtl/otp_mem_ctrl.sv
module otp_mem_ctrl
   import otp_mem_pkg::*;
#(
   parameter int                ADDR_W    = 10,
   parameter int                DATA_W    = 8,
   parameter int                OUT_REG   = 1,
   parameter logic [DATA_W-1:0] MFR_CODE  = 'h1C,
   parameter logic [DATA_W-1:0] DEV_CODE  = 'h83,
   parameter logic [DATA_W-1:0] CONT_CODE = 'h7F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              vpp_hi,
   input  logic              id_hi,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);

   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("otp_mem_ctrl: ADDR_W must be at least 2 for identification select");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("otp_mem_ctrl: DATA_W must be positive");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_out_reg
      $error("otp_mem_ctrl: OUT_REG must be 0 or 1");
   end

   otp_mode_e         mode;
   logic [DATA_W-1:0] cell_q;
   logic [DATA_W-1:0] id_code;
   logic              nxt_oe;
   logic [DATA_W-1:0] nxt_data;

   otp_mode_decode u_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .vpp_hi (vpp_hi),
      .id_hi  (id_hi),
      .mode   (mode)
   );

   otp_cell_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mode == MODE_PROGRAM),
      .addr    (addr),
      .wr_data (dq_in),
      .rd_data (cell_q)
   );

   otp_id_source #(
      .DATA_W    (DATA_W),
      .MFR_CODE  (MFR_CODE),
      .DEV_CODE  (DEV_CODE),
      .CONT_CODE (CONT_CODE)
   ) u_id (
      .sel_dev (addr[0]),
      .id_page (addr[1]),
      .code    (id_code)
   );

   always_comb begin
      nxt_oe = mode_drives(mode);
      if (mode == MODE_IDENT)
         nxt_data = id_code;
      else if (mode == MODE_READ)
         nxt_data = cell_q;
      else
         nxt_data = '0;
   end

   if (OUT_REG == 1) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
         end else begin
            dq_oe  <= nxt_oe;
            dq_out <= nxt_data;
         end
      end
   end else begin : g_out_comb
      assign dq_oe  = rst_n & nxt_oe;
      assign dq_out = rst_n ? nxt_data : '0;
   end

endmodule

// File: rtl/otp_mem_ctrl_chk.sv
module otp_mem_ctrl_chk #(
   parameter int                ADDR_W    = 10,
   parameter int                DATA_W    = 8,
   parameter int                OUT_REG   = 1,
   parameter logic [DATA_W-1:0] MFR_CODE  = 'h1C,
   parameter logic [DATA_W-1:0] DEV_CODE  = 'h83,
   parameter logic [DATA_W-1:0] CONT_CODE = 'h7F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              vpp_hi,
   input logic              id_hi,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] dq_out,
   input logic              dq_oe
);

   // Inputs aligned with the output latency of the design.
   logic              a_ce_n, a_oe_n, a_vpp, a_id;
   logic [1:0]        a_sel;

   if (OUT_REG == 1) begin : g_align_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_ce_n <= 1'b1;
            a_oe_n <= 1'b1;
            a_vpp  <= 1'b0;
            a_id   <= 1'b0;
            a_sel  <= '0;
         end else begin
            a_ce_n <= ce_n;
            a_oe_n <= oe_n;
            a_vpp  <= vpp_hi;
            a_id   <= id_hi;
            a_sel  <= addr[1:0];
         end
      end
   end else begin : g_align_comb
      assign a_ce_n = ce_n;
      assign a_oe_n = oe_n;
      assign a_vpp  = vpp_hi;
      assign a_id   = id_hi;
      assign a_sel  = addr[1:0];
   end

   logic rd_ident;
   assign rd_ident = !a_ce_n && !a_oe_n && !a_vpp && a_id;

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!dq_oe && dq_out == '0); // R1
      end
   end

   AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (a_ce_n && !a_vpp) |-> !dq_oe); // R2

   AST_DISABLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_ce_n && a_oe_n && !a_vpp) |-> !dq_oe); // R3

   AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_ce_n && !a_oe_n && !a_vpp && !a_id) |-> dq_oe); // R4

   AST_PROGRAM_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_ce_n && a_vpp) |-> !dq_oe); // R6

   AST_INHIBIT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (a_ce_n && a_vpp) |-> !dq_oe); // R8

   AST_ID_MAKER: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ident && a_sel == 2'b10) |-> (dq_oe && dq_out == MFR_CODE)); // R9

   AST_ID_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ident && a_sel == 2'b11) |-> (dq_oe && dq_out == DEV_CODE)); // R9

   AST_ID_CONT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ident && !a_sel[1]) |-> (dq_oe && dq_out == CONT_CODE)); // R10

   AST_ID_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ident && a_sel[1]) |-> (^dq_out == 1'b1)); // R11

endmodule

bind otp_mem_ctrl otp_mem_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .OUT_REG   (OUT_REG),
   .MFR_CODE  (MFR_CODE),
   .DEV_CODE  (DEV_CODE),
   .CONT_CODE (CONT_CODE)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ce_n   (ce_n),
   .oe_n   (oe_n),
   .vpp_hi (vpp_hi),
   .id_hi  (id_hi),
   .addr   (addr),
   .dq_out (dq_out),
   .dq_oe  (dq_oe)
);

// File: tb/tb_otp_mem_ctrl.sv
module tb_otp_mem_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int AW    = 10;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ce_n, oe_n, vpp_hi, id_hi;
   logic [AW-1:0] addr;
   logic [7:0]    dq_in;
   logic [7:0]    dq_out;
   logic          dq_oe;

   otp_mem_ctrl #(.ADDR_W(AW), .DATA_W(8)) dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .vpp_hi (vpp_hi),
      .id_hi  (id_hi),
      .addr   (addr),
      .dq_in  (dq_in),
      .dq_out (dq_out),
      .dq_oe  (dq_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int         due;
      logic       exp_oe;
      logic [7:0] exp_d;
      logic       par;
      string      req;
   } item_t;

   item_t      sb[$];
   logic [7:0] ref_mem [DEPTH];
   int         cycle  = 0;
   int         checks = 0;
   int         fails  = 0;

   always @(posedge clk) cycle <= cycle + 1;

   // Monitor: pops expectations whose cycle has come and compares them.
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cycle) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (dq_oe !== it.exp_oe) begin
            fails++;
            $display("FAIL %s: dq_oe actual=%b expected=%b", it.req, dq_oe, it.exp_oe);
         end else if (it.exp_oe && dq_out !== it.exp_d) begin
            fails++;
            $display("FAIL %s: dq_out actual=%h expected=%h", it.req, dq_out, it.exp_d);
         end
         if (it.par) begin
            checks++;
            if (^dq_out !== 1'b1) begin
               fails++;
               $display("FAIL R11: parity actual=%b expected=1 (byte %h)", ^dq_out, dq_out);
            end
         end
      end
   end

   // Driver: applies one cycle of stimulus and pushes the expected result.
   task automatic drive(input logic c, input logic o, input logic v, input logic i,
                        input logic [AW-1:0] a, input logic [7:0] d, input string req);
      item_t it;
      @(negedge clk);
      ce_n = c; oe_n = o; vpp_hi = v; id_hi = i; addr = a; dq_in = d;
      it.due = cycle + 1; it.exp_d = 8'h00; it.par = 1'b0; it.req = req;
      if (c) begin
         it.exp_oe = 1'b0;
      end else if (v) begin
         it.exp_oe = 1'b0;
         ref_mem[a] = ref_mem[a] & d;
      end else if (o) begin
         it.exp_oe = 1'b0;
      end else if (i) begin
         it.exp_oe = 1'b1;
         it.exp_d  = a[1] ? (a[0] ? 8'h83 : 8'h1C) : 8'h7F;
         it.par    = a[1];
      end else begin
         it.exp_oe = 1'b1;
         it.exp_d  = ref_mem[a];
      end
      sb.push_back(it);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      for (int k = 0; k < DEPTH; k++) ref_mem[k] = 8'hFF;
      rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b0; id_hi = 1'b0;
      addr = '0; dq_in = 8'h00;
      repeat (3) @(negedge clk);
      // R1: quiet bus while reset is held, even with a read requested
      checks++;
      if (dq_oe !== 1'b0 || dq_out !== 8'h00) begin
         fails++;
         $display("FAIL R1: oe/out actual=%b/%h expected=0/00", dq_oe, dq_out);
      end
      ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;

      // R5/R4: erased reads at several addresses
      drive(0, 0, 0, 0, 10'd0,   8'h00, "R5");
      drive(0, 0, 0, 0, 10'd5,   8'h00, "R5");
      drive(0, 0, 0, 0, 10'h3FF, 8'h00, "R4");
      // R2: standby with either output enable
      drive(1, 0, 0, 0, 10'd5, 8'h00, "R2");
      drive(1, 1, 0, 0, 10'd5, 8'h00, "R2");
      // R3: output disable, also with the identification flag raised
      drive(0, 1, 0, 0, 10'd5,   8'h00, "R3");
      drive(0, 1, 0, 1, 10'h3FE, 8'h00, "R3");
      // R6: program then verify
      drive(0, 1, 1, 0, 10'd5, 8'hA5, "R6");
      drive(0, 0, 0, 0, 10'd5, 8'h00, "R6");
      // R7: attempts to restore cleared bits
      drive(0, 0, 1, 0, 10'd5, 8'h5F, "R7");
      drive(0, 0, 0, 0, 10'd5, 8'h00, "R7");
      drive(0, 1, 1, 0, 10'd5, 8'hFF, "R7");
      drive(0, 0, 0, 0, 10'd5, 8'h00, "R7");
      // R8: inhibited program leaves the cell erased
      drive(1, 1, 1, 0, 10'd7, 8'h00, "R8");
      drive(0, 0, 0, 0, 10'd7, 8'h00, "R8");
      // R6: top address written, neighbour untouched
      drive(0, 1, 1, 0, 10'h3FF, 8'h3C, "R6");
      drive(0, 0, 0, 0, 10'h3FF, 8'h00, "R6");
      drive(0, 0, 0, 0, 10'h3FE, 8'h00, "R6");
      // R9/R10/R11: identification bytes
      drive(0, 0, 0, 1, 10'h3FE, 8'h00, "R9");
      drive(0, 0, 0, 1, 10'h3FF, 8'h00, "R9");
      drive(0, 0, 0, 1, 10'h3FD, 8'h00, "R10");
      drive(0, 0, 0, 1, 10'h3FC, 8'h00, "R10");
      // R9: identification does not disturb the array
      drive(0, 0, 0, 0, 10'h3FF, 8'h00, "R9");
      drive(1, 1, 0, 0, 10'd0,   8'h00, "R2");
      repeat (3) @(negedge clk);
      summary();
      $finish;
   end

endmodule